// File: doc/BRIEF.md
# Eight-Input Maskable Interrupt Controller

This block gathers level-sensitive service requests from eight peripherals and merges them into one interrupt line for a processor. Each input can be blocked by its own bit in an 8-bit mask register, which software writes and reads back through a small register port. Whenever at least one unblocked input is high, the interrupt line is high. Next to it the block offers a 3-bit vector naming the winning input, and the lowest unblocked index wins.

The processor takes the interrupt by raising an acknowledge strobe. While the strobe is high, the vector appears on an 8-bit read-data bus. The vector is captured in the first acknowledge cycle and held until the strobe falls, so changes on the request pins during the read cannot corrupt it. Outside acknowledge the bus reads zero.

Per-line masking is the only protection against re-entry. The service routine blocks its own line and unblocks it again when it is done.

Top module: `intc_mask8`

## Requirements
- R1: After reset the mask register reads 0xFF (every input blocked), and the interrupt line is low whatever the request inputs are.
- R2: A write on the register port (write strobe high) loads all eight mask bits at the clock edge. The new value reads back on the read port from the next cycle on. A 1 in bit i blocks input i.
- R3: The interrupt line is high in a cycle exactly when some input i is high and its mask bit i is 0. It follows the inputs within the same cycle.
- R4: A blocked input changes neither the interrupt line nor the offered vector, even when it is high.
- R5: While the interrupt line is high, the offered vector equals the lowest index among the high, unblocked inputs.
- R6: While acknowledge is high, the data bus carries the vector in bits 2:0 and zeros in bits 7:3. In the first acknowledge cycle this is the vector offered in that cycle. That value is held unchanged until acknowledge falls.
- R7: While acknowledge is low, the data bus is 0x00.
- R8: When one unblocked input drops while another unblocked input stays high, the interrupt line stays high and the vector moves to the remaining input.
- R9: An acknowledge with no unblocked request pending reads vector 0 (bus 0x00).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 8 | Level-sensitive requests, bit i from peripheral i |
| mask_wr_i | input | 1 | Mask register write strobe |
| mask_wdata_i | input | 8 | Mask write value, 1 blocks the input |
| mask_rdata_o | output | 8 | Current mask register value |
| irq_o | output | 1 | Combined interrupt request to the processor |
| vec_o | output | 3 | Vector of the winning input |
| ack_i | input | 1 | Processor acknowledge strobe |
| data_o | output | 8 | Read-data bus: vector during acknowledge, else zero |

## Verification
Walking single requests with everything unblocked show that each index maps to its own vector. Dense and all-ones request patterns separate lowest-index priority from any other ordering. Request patterns that sit entirely on blocked lines, or that mix blocked low indices with unblocked high ones, show whether masking hides a line from both the interrupt line and the vector. Acknowledge pulses whose requests change mid-pulse, or that arrive with nothing pending, tell a held vector apart from a live one, and a long pseudo-random run mixes all of these patterns with mask rewrites.

// File: rtl/intc_pkg.sv
// Shared sizing for the interrupt controller.
package intc_pkg;
    localparam int N_IRQ  = 8;
    localparam int VEC_W  = $clog2(N_IRQ);
    localparam int DATA_W = 8;
endpackage

// File: rtl/intc_mask_reg.sv
// Mask register: holds one block bit per input line.
// Assumes whole-register writes; resets to all ones (all inputs blocked).
module intc_mask_reg #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_i,
    input  logic [N-1:0] wdata_i,
    output logic [N-1:0] mask_o
);
    logic [N-1:0] mask_q;

    // Load the mask on a write, force all-blocked on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)    mask_q <= '1;
        else if (wr_i) mask_q <= wdata_i;
    end

    assign mask_o = mask_q;
endmodule

// File: rtl/intc_prio.sv
// Lowest-index-first priority encoder over the pending lines.
// Assumes an index of 0 is reported when nothing is pending.
module intc_prio #(
    parameter int N = 8,
    localparam int VW = $clog2(N)
) (
    input  logic [N-1:0]  pend_i,
    output logic          any_o,
    output logic [VW-1:0] vec_o
);
    logic [N-1:0] seen;   // seen[i]: some line at index <= i is pending
    logic [N-1:0] grant;  // one-hot winner

    assign seen[0]  = pend_i[0];
    assign grant[0] = pend_i[0];

    genvar g;
    generate
        for (g = 1; g < N; g++) begin : g_chain
            assign seen[g]  = seen[g-1] | pend_i[g];
            assign grant[g] = pend_i[g] & ~seen[g-1];
        end
    endgenerate

    assign any_o = seen[N-1];

    // Turn the one-hot grant into a binary index.
    always_comb begin
        vec_o = '0;
        for (int i = 0; i < N; i++) begin
            if (grant[i]) vec_o = vec_o | VW'(i);
        end
    end
endmodule

// File: rtl/intc_vec_hold.sv
// Acknowledge-side vector capture and read-data bus drive.
// Assumes the live vector is valid in the cycle acknowledge first goes high.
module intc_vec_hold #(
    parameter int VW = 3,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ack_i,
    input  logic [VW-1:0] live_vec_i,
    output logic [DW-1:0] data_o
);
    logic          ack_q;
    logic [VW-1:0] held_q;
    logic [VW-1:0] shown;

    // Track acknowledge and capture the vector in its first cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_q  <= 1'b0;
            held_q <= '0;
        end else begin
            ack_q <= ack_i;
            if (ack_i && !ack_q) held_q <= live_vec_i;
        end
    end

    // First ack cycle shows the live vector, later cycles the held one.
    always_comb begin
        shown  = ack_q ? held_q : live_vec_i;
        data_o = ack_i ? {{(DW-VW){1'b0}}, shown} : '0;
    end
endmodule

// File: rtl/intc_mask8.sv
// Top: eight-input maskable interrupt controller.
// Combines unblocked level requests into one interrupt line, offers the
// lowest winning index as vector, and drives it on the read bus during ack.
module intc_mask8
    import intc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_IRQ-1:0]  req_i,
    input  logic              mask_wr_i,
    input  logic [N_IRQ-1:0]  mask_wdata_i,
    output logic [N_IRQ-1:0]  mask_rdata_o,
    output logic              irq_o,
    output logic [VEC_W-1:0]  vec_o,
    input  logic              ack_i,
    output logic [DATA_W-1:0] data_o
);
    logic [N_IRQ-1:0] mask;
    logic [N_IRQ-1:0] pend;

    intc_mask_reg #(.N(N_IRQ)) u_mask (
        .clk(clk), .rst_n(rst_n), .wr_i(mask_wr_i),
        .wdata_i(mask_wdata_i), .mask_o(mask)
    );

    assign pend         = req_i & ~mask;
    assign mask_rdata_o = mask;

    intc_prio #(.N(N_IRQ)) u_prio (
        .pend_i(pend), .any_o(irq_o), .vec_o(vec_o)
    );

    intc_vec_hold #(.VW(VEC_W), .DW(DATA_W)) u_hold (
        .clk(clk), .rst_n(rst_n), .ack_i(ack_i),
        .live_vec_i(vec_o), .data_o(data_o)
    );
endmodule

// File: rtl/intc_mask8_chk.sv
// Checker for intc_mask8, attached by bind below.
module intc_mask8_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] req_i,
    input logic [7:0] mask_rdata_o,
    input logic       irq_o,
    input logic [2:0] vec_o,
    input logic       ack_i,
    input logic [7:0] data_o
);
    logic [7:0] pend_v;
    logic [7:0] below_v;
    assign pend_v  = req_i & ~mask_rdata_o;
    assign below_v = pend_v & ((8'd1 << vec_o) - 8'd1);

    assert_mask_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> mask_rdata_o == 8'hFF);

    assert_irq_needs_pend_R3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> pend_v != 8'h00);

    assert_lowest_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (pend_v[vec_o] && below_v == 8'h00));

    assert_held_vec_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && $past(ack_i)) |-> $stable(data_o));

    assert_upper_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        data_o[7:3] == 5'd0);

    assert_idle_bus_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_i |-> data_o == 8'h00);
endmodule

bind intc_mask8 intc_mask8_chk chk_i (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .mask_rdata_o(mask_rdata_o),
    .irq_o(irq_o), .vec_o(vec_o), .ack_i(ack_i), .data_o(data_o)
);

// File: tb/intc_mask8_tb_top.sv
// Bench: behavioural reference model compared on every clock.
module intc_mask8_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] req = 8'h00;
    logic       wr = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic       ack = 1'b0;
    logic [7:0] rdata;
    logic       irq;
    logic [2:0] vec;
    logic [7:0] data;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference state
    int m_mask = 8'hFF;
    int m_held = 0;
    bit m_ackp = 0;

    always #2 clk = ~clk;  // 250 MHz

    intc_mask8 dut_i (
        .clk(clk), .rst_n(rst_n), .req_i(req), .mask_wr_i(wr),
        .mask_wdata_i(wdata), .mask_rdata_o(rdata), .irq_o(irq),
        .vec_o(vec), .ack_i(ack), .data_o(data)
    );

    function automatic int m_pend();
        return int'(req) & ~m_mask & 8'hFF;
    endfunction

    function automatic int m_vec();
        int p = m_pend();
        for (int i = 0; i < 8; i++) if (p[i]) return i;
        return 0;
    endfunction

    // Reference model state update at each clock.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_mask = 8'hFF; m_held = 0; m_ackp = 0;
        end else begin
            if (ack && !m_ackp) m_held = m_vec();
            if (wr) m_mask = int'(wdata);
            m_ackp = ack;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model (sampled 1 ns before the edge).
    task automatic compare_all();
        int ev;
        chk("R2 readback", int'(rdata), m_mask);
        chk("R3 irq", int'(irq), int'(m_pend() != 0));
        if (m_pend() != 0) chk("R5 vector", int'(vec), m_vec());
        if (ack) begin
            ev = m_ackp ? m_held : m_vec();
            chk("R6 ack bus", int'(data), ev);
        end else begin
            chk("R7 idle bus", int'(data), 0);
        end
    endtask

    task automatic step(input logic [7:0] r, input logic w, input logic [7:0] wd, input logic a);
        @(negedge clk);
        req = r; wr = w; wdata = wd; ack = a;
        #1;
        if (rst_n) compare_all();
    endtask

    initial begin
        logic [7:0] lfsr;
        // reset with requests high
        rst_n = 1'b0;
        step(8'hFF, 1'b0, 8'h00, 1'b0);
        step(8'hFF, 1'b0, 8'h00, 1'b0);
        step(8'hFF, 1'b0, 8'h00, 1'b0);
        @(negedge clk); rst_n = 1'b1; #1;
        chk("R1 mask reset", int'(rdata), 8'hFF);
        chk("R1 irq low", int'(irq), 0);
        compare_all();

        // unblock all
        step(8'hFF, 1'b1, 8'h00, 1'b0);
        step(8'h00, 1'b0, 8'h00, 1'b0);
        chk("R2 write", int'(rdata), 8'h00);

        // walking single requests
        for (int i = 0; i < 8; i++) begin
            step(8'(1 << i), 1'b0, 8'h00, 1'b0);
            chk("R5 walk", int'(vec), i);
        end
        step(8'hFF, 1'b0, 8'h00, 1'b0);
        chk("R5 all high", int'(vec), 0);
        step(8'hA8, 1'b0, 8'h00, 1'b0);
        chk("R5 dense", int'(vec), 3);

        // masking
        step(8'h00, 1'b1, 8'hF0, 1'b0);
        step(8'hF0, 1'b0, 8'h00, 1'b0);
        chk("R4 masked irq", int'(irq), 0);
        step(8'hF3, 1'b0, 8'h00, 1'b0);
        chk("R4 masked vec", int'(vec), 0);
        step(8'h00, 1'b1, 8'h0F, 1'b0);
        step(8'h0F | 8'h40, 1'b0, 8'h00, 1'b0);
        chk("R4 low lines masked", int'(vec), 6);

        // one drops, another stays
        step(8'h00, 1'b1, 8'h00, 1'b0);
        step(8'h18, 1'b0, 8'h00, 1'b0);
        chk("R8 before drop", int'(vec), 3);
        step(8'h10, 1'b0, 8'h00, 1'b0);
        chk("R8 irq stays", int'(irq), 1);
        chk("R8 vector moves", int'(vec), 4);

        // ack with changing requests
        step(8'h20, 1'b0, 8'h00, 1'b1);
        chk("R6 first ack", int'(data), 5);
        step(8'h02, 1'b0, 8'h00, 1'b1);
        chk("R6 held", int'(data), 5);
        step(8'h00, 1'b0, 8'h00, 1'b1);
        chk("R6 held 2", int'(data), 5);
        step(8'h02, 1'b0, 8'h00, 1'b0);
        chk("R7 after ack", int'(data), 0);

        // ack with nothing pending
        step(8'h00, 1'b0, 8'h00, 1'b1);
        chk("R9 empty ack", int'(data), 0);
        step(8'h80, 1'b0, 8'h00, 1'b1);
        chk("R9 held zero", int'(data), 0);
        step(8'h00, 1'b0, 8'h00, 1'b0);

        // pseudo-random mix
        lfsr = 8'h5B;
        for (int n = 0; n < 400; n++) begin
            logic [7:0] r;
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            r = lfsr ^ 8'(n);
            step(r, (n % 13) == 0, lfsr ^ 8'h3C, ((n / 3) % 3) == 0);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        #200000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule